// File: doc/BRIEF.md
# UART Oversampling Tick Generator

This block divides the system clock down to a single-cycle enable pulse at sixteen times the serial bit rate. The transmit and receive bit-timing logic of a UART channel uses that pulse as its sampling strobe. Software programs one 16-bit control word. The word holds a 12-bit division value, which is the wanted ratio minus one, an enable, a prescaler select and a reset request. The prescaler select inserts an extra divide-by-16 stage for ratios that do not fit in 12 bits.

The reset request clears the prescaler and the main counter. The request bit reads back as 1 until the hardware has finished, so software can poll it. The main counter counts prescaled strobes down to zero. On each strobe at zero it reloads from the division field and issues a tick. Because of this, a new division value is picked up only at a reload.

Top module: `baud_tick_gen`

## Requirements
- R1: The control word holds the prescaler select in bit 0, the division value D in bits 12..1, the enable in bit 13 and the reset request in bit 14. A read returns the stored select, division and enable in the same positions, the reset status in bit 14 and 0 in bit 15. After the synchronous reset `rst`, the read value is 0 and `tick_x16` is low.
- R2: While the enable is 0, `tick_x16` stays low, and the prescaler and the counter hold their values.
- R3: With the prescaler select set, one strobe reaches the main counter every 16 enabled cycles, so ticks are 16·(D+1) cycles apart and never fall in adjacent cycles.
- R4: With the prescaler select clear, every enabled cycle is a strobe, so ticks are D+1 cycles apart. With D = 0, `tick_x16` stays high continuously.
- R5: A write with bit 14 set makes bit 14 of the read value 1 for the next two cycles; it then returns to 0 on its own.
- R6: From the write of the reset request until bit 14 clears, the prescaler and the counter are held at zero and no tick is issued. The first strobe after that produces a tick.
- R7: A tick is one cycle long. It appears in the cycle after a strobe finds the counter at zero, and at that strobe the counter reloads with D.
- R8: A new D written while the counter is running does not change the count in progress. It is used from the next reload onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word to write |
| cfg_rdata | output | 16 | Read-back of the control word and the reset status |
| tick_x16 | output | 1 | Oversampling tick, one cycle per division period |

## Verification
The reset request and a reload can fall in the same cycle. The bench writes the reset bit at several points while ticks are running, including the cycle in which the counter reaches zero. The reset must win: no tick may follow, and the counter must restart from zero. A new division value can also arrive in the cycle of a reload. The bench rewrites D both mid-count and right after a tick, and the gap before and after the write is measured. A cycle-by-cycle model checks every tick and every read-back value.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int DIV_W   = 12;
    localparam int PRE_W   = 4;
    localparam int CTL_W   = DIV_W + 4;
    localparam int POS_PRE = 0;
    localparam int POS_DIV = 1;
    localparam int POS_EN  = DIV_W + 1;
    localparam int POS_RST = DIV_W + 2;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
        logic             presel;
    } cfg_t;

    function automatic cfg_t unpack_cfg(input logic [CTL_W-1:0] w);
        cfg_t c;
        c.presel = w[POS_PRE];
        c.div    = w[POS_DIV +: DIV_W];
        c.en     = w[POS_EN];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] pack_status(input cfg_t c, input logic busy);
        logic [CTL_W-1:0] w;
        w                   = '0;
        w[POS_PRE]          = c.presel;
        w[POS_DIV +: DIV_W] = c.div;
        w[POS_EN]           = c.en;
        w[POS_RST]          = busy;
        return w;
    endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
    import baud_pkg::*;
#(
    parameter int RST_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [CTL_W-1:0] wdata_i,
    output cfg_t             cfg_o,
    output logic             busy_o,
    output logic             clr_o
);
    localparam int RC_W = $clog2(RST_CYC + 1);

    cfg_t            cfg_q;
    logic [RC_W-1:0] rc_q;
    logic            rst_req;

    assign rst_req = we_i && wdata_i[POS_RST];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            rc_q  <= '0;
        end else begin
            if (we_i) begin
                cfg_q <= unpack_cfg(wdata_i);
            end
            if (rst_req) begin
                rc_q <= RC_W'(RST_CYC);
            end else if (rc_q != '0) begin
                rc_q <= rc_q - 1'b1;
            end
        end
    end

    assign cfg_o  = cfg_q;
    assign busy_o = (rc_q != '0);
    assign clr_o  = rst_req || busy_o;

    AST_RST_SETS: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> busy_o); // R5
    AST_RST_SELFCLR: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(busy_o, 2)); // R5

endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
    import baud_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic en_i,
    input  logic sel_i,
    output logic stb_o
);
    localparam logic [W-1:0] PRE_MAX = {W{1'b1}};

    logic [W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pre_q <= '0;
        end else if (en_i) begin
            if (sel_i) begin
                pre_q <= pre_q + 1'b1;
            end else begin
                pre_q <= '0;
            end
        end
    end

    assign stb_o = en_i && !clr_i && (!sel_i || (pre_q == PRE_MAX));

    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !clr_i) |=> $stable(pre_q)); // R2
    AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (pre_q == '0)); // R6

endmodule

// File: rtl/baud_divcnt.sv
module baud_divcnt
    import baud_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         stb_i,
    input  logic         en_i,
    input  logic         presel_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_q;
    logic         tick_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= stb_i && (cnt_q == '0);
            if (stb_i) begin
                if (cnt_q == '0) begin
                    cnt_q <= div_i;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign tick_o = tick_q;

    AST_NO_TICK_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !tick_o); // R2
    AST_PRESCALED_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick_o && $past(presel_i)) |-> !$past(tick_o)); // R3
    AST_CLEAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0 && !tick_o)); // R6
    AST_TICK_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> ($past(cnt_q) == '0)); // R7
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !$past(clr_i)) |-> (cnt_q == $past(div_i))); // R8

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int RST_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CTL_W-1:0] cfg_wdata,
    output logic [CTL_W-1:0] cfg_rdata,
    output logic             tick_x16
);
    cfg_t cfg;
    logic busy;
    logic clr;
    logic stb;

    baud_cfg_reg #(.RST_CYC(RST_CYC)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .cfg_o   (cfg),
        .busy_o  (busy),
        .clr_o   (clr)
    );

    baud_prescale #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr),
        .en_i  (cfg.en),
        .sel_i (cfg.presel),
        .stb_o (stb)
    );

    baud_divcnt #(.W(DIV_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (clr),
        .stb_i    (stb),
        .en_i     (cfg.en),
        .presel_i (cfg.presel),
        .div_i    (cfg.div),
        .tick_o   (tick_x16)
    );

    assign cfg_rdata = pack_status(cfg, busy);

    AST_STATUS_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[CTL_W-1] == 1'b0); // R1

endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        tick_x16;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string phase = "R1";

    // reference model state
    int m_pre = 0, m_cnt = 0, m_rc = 0;
    bit m_tick = 0, m_en = 0, m_sel = 0;
    int m_div = 0;

    always #4 clk = ~clk;

    baud_tick_gen u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tick_x16(tick_x16)
    );

    function automatic logic [15:0] word(bit en, int d, bit sel, bit rq);
        return {1'b0, rq, en, d[11:0], sel};
    endfunction

    always @(posedge clk) begin
        int n_pre, n_cnt, n_rc;
        bit n_tick, stb, clr;
        cycles++;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_rc = 0; m_tick = 0;
            m_en = 0; m_sel = 0; m_div = 0;
        end else begin
            clr = (cfg_we && cfg_wdata[14]) || (m_rc != 0);
            n_pre = m_pre; n_cnt = m_cnt; n_tick = 0; stb = 0;
            if (clr) begin
                n_pre = 0; n_cnt = 0;
            end else if (m_en) begin
                if (m_sel) begin
                    stb = (m_pre == 15);
                    n_pre = (m_pre + 1) % 16;
                end else begin
                    stb = 1; n_pre = 0;
                end
                if (stb) begin
                    n_tick = (m_cnt == 0);
                    n_cnt = (m_cnt == 0) ? m_div : m_cnt - 1;
                end
            end
            if (cfg_we && cfg_wdata[14]) n_rc = 2;
            else n_rc = (m_rc > 0) ? m_rc - 1 : 0;
            if (cfg_we) begin
                m_en = cfg_wdata[13]; m_div = int'(cfg_wdata[12:1]); m_sel = cfg_wdata[0];
            end
            m_pre = n_pre; m_cnt = n_cnt; m_tick = n_tick; m_rc = n_rc;
        end
    end

    always @(negedge clk) begin
        logic [15:0] exp_rd;
        if (!rst) begin
            exp_rd = {1'b0, (m_rc != 0), m_en, m_div[11:0], m_sel};
            checks++;
            if (tick_x16 !== m_tick) begin
                fails++;
                $display("FAIL %s tick: actual %0b expected %0b at cycle %0d", phase, tick_x16, m_tick, cycles);
            end
            checks++;
            if (cfg_rdata !== exp_rd) begin
                fails++;
                $display("FAIL %s rdata: actual %h expected %h at cycle %0d", phase, cfg_rdata, exp_rd, cycles);
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write(logic [15:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    // counts negedges until tick is sampled high
    task automatic gap(output int g);
        g = 0;
        do begin
            @(negedge clk); g++;
        end while (!tick_x16 && g < 5000);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int g, hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset rdata", int'(cfg_rdata), 0);
        check("R1 reset tick", int'(tick_x16), 0);

        // R4 / R7 plain division
        phase = "R4";
        write(word(1, 3, 0, 0));
        gap(g); gap(g); check("R4 gap D=3", g, 4);
        gap(g); check("R7 gap D=3 repeat", g, 4);
        check("R1 readback", int'(cfg_rdata), int'(word(1, 3, 0, 0)));

        // R4 D=0 continuous
        write(word(1, 0, 0, 0));
        repeat (4) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); hi += tick_x16;
        end
        check("R4 D=0 ticks in 20", hi, 20);

        // R3 prescaled
        phase = "R3";
        write(word(1, 1, 1, 0));
        gap(g); gap(g); check("R3 gap presel D=1", g, 32);
        gap(g); check("R3 gap presel repeat", g, 32);

        // R2 disabled
        phase = "R2";
        write(word(0, 1, 1, 0));
        hi = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk); hi += tick_x16;
        end
        check("R2 ticks while disabled", hi, 0);
        check("R1 readback disabled", int'(cfg_rdata), int'(word(0, 1, 1, 0)));

        // R5 / R6 reset request
        phase = "R5";
        write(word(1, 5, 0, 0));
        gap(g);
        repeat (2) @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = word(1, 2, 0, 1);
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
        check("R5 busy first cycle", int'(cfg_rdata[14]), 1);
        check("R6 no tick in reset", int'(tick_x16), 0);
        @(negedge clk);
        check("R5 busy second cycle", int'(cfg_rdata[14]), 1);
        check("R6 no tick in reset 2", int'(tick_x16), 0);
        @(negedge clk);
        check("R5 busy cleared", int'(cfg_rdata[14]), 0);
        @(negedge clk);
        check("R6 first strobe ticks", int'(tick_x16), 1);
        gap(g); check("R6 gap after reset", g, 3);

        // reset request landing on a reload cycle
        phase = "R6";
        write(word(1, 3, 0, 0));
        gap(g); gap(g);
        repeat (2) @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = word(1, 3, 0, 1);
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
        check("R6 reset over reload tick", int'(tick_x16), 0);
        repeat (3) @(negedge clk);

        // R8 divider change mid-count
        phase = "R8";
        write(word(1, 9, 0, 0));
        gap(g); gap(g);
        repeat (3) @(negedge clk);
        write(word(1, 2, 0, 0));
        gap(g); check("R8 count in progress kept", g + 4, 10);
        gap(g); check("R8 new D after reload", g, 3);

        // R8 divider change right after a tick
        write(word(1, 6, 0, 0));
        gap(g);
        write(word(1, 1, 0, 0));
        gap(g); check("R8 old D finishes", g + 1, 7);
        gap(g); check("R8 new D used", g, 2);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule